// File: doc/BRIEF.md
# Three-Entry Sequence Lock

This block is a clocked lock. It compares a sequence of three entered values against a combination held inside the block. Each entry arrives together with a one-cycle strobe. The controller keeps track of which step of the sequence it has reached. The one-hot code of that step drives a multiplexer, which picks the stored value for the step, and an equality comparator checks the picked value against the entry in the same cycle. The lock releases only when all three entries match and arrive in the correct order.

The state register is encoded so that the outputs come straight from it. Its low three bits are the one-hot multiplexer select, and its top bit is the unlock output. Both outputs are therefore registered. In the default mode, a wrong entry moves the lock to a locked-out state at once. When `defer_verdict` is high, a wrong entry is only noted. The lock keeps accepting strobes and gives its verdict after the third entry, so it does not reveal which entry was wrong. The unlocked state and the locked-out state are both left only through reset.

Top module: `seq_lock`

## Requirements
- R1: A synchronous active-high `rst` puts the lock in step one. The cycle after a reset edge shows `sel` = 3'b001 and `unlocked` = 0, whatever the mode.
- R2: `sel` is the one-hot code of the current step: 3'b001 in step one, 3'b010 in step two, 3'b100 in step three. It is 3'b000 in the unlocked state and in the locked-out state.
- R3: `unlocked` is 1 only in the unlocked state, and the unlocked state shows `sel` = 3'b000. Every other state drives `unlocked` = 0.
- R4: A cycle with `strobe` low leaves the state unchanged, whatever value is on `entry`.
- R5: In step one, step two and step three, a strobed entry equal to the stored value for that step moves the lock on by one step. From step three it moves to the unlocked state. The default combination is 3, then 4, then 2, and each step compares only against its own stored value.
- R6: With `defer_verdict` = 0, a strobed entry that does not match in step one, two or three moves the lock to the locked-out state (`sel` = 3'b000, `unlocked` = 0) at the next edge.
- R7: The unlocked state and the locked-out state hold through any strobes and any entries until reset.
- R8: Reset takes priority over a strobe in the same cycle, and it returns the lock to step one from every state, including the unlocked and locked-out states.
- R9: With `defer_verdict` = 1, a mismatch in step one or step two still moves `sel` on to the next one-hot step. After the third strobed entry the lock goes to the locked-out state if any of the three entries was wrong.
- R10: With `defer_verdict` = 1, three correct entries in order unlock the lock on the third strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| defer_verdict | input | 1 | 1: give the verdict only after three entries |
| strobe | input | 1 | One-cycle flag that marks a new entry |
| entry | input | VAL_W | Entered value |
| unlocked | output | 1 | Unlock output (top state bit) |
| sel | output | 3 | One-hot select of the stored value (low state bits) |

## Verification
The hardest condition to reach is in deferred mode. There, a recorded mismatch is invisible at the outputs until the third entry. A wrong first or second entry looks exactly like a correct one, because `sel` advances in both cases. The stimulus therefore places the wrong entry in each of the three positions in turn, and after an early mismatch it follows with correct entries. The only visible difference is then whether the third strobe lands on the unlocked state or on the locked-out state. Further vectors feed a step the value stored for a different step, which shows that the select picks the right slot. Other vectors assert reset together with a matching strobe.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int STEPS = 3;
  localparam int ST_W  = STEPS + 1;

  // low STEPS bits = one-hot compare select, top bit = unlocked
  localparam logic [ST_W-1:0] ST_LOCKOUT = 4'b0000;
  localparam logic [ST_W-1:0] ST_ONE     = 4'b0001;
  localparam logic [ST_W-1:0] ST_TWO     = 4'b0010;
  localparam logic [ST_W-1:0] ST_THREE   = 4'b0100;
  localparam logic [ST_W-1:0] ST_OPEN    = 4'b1000;
endpackage

// File: rtl/lock_key_store.sv
module lock_key_store
  import lock_pkg::*;
#(
  parameter int VAL_W = 4,
  parameter logic [STEPS*VAL_W-1:0] COMBO = {VAL_W'(2), VAL_W'(4), VAL_W'(3)}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [STEPS-1:0] pick,
  output logic [VAL_W-1:0] picked
);
  logic [VAL_W-1:0] slot_q [STEPS];
  logic [VAL_W-1:0] gated  [STEPS];

  for (genvar i = 0; i < STEPS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) slot_q[i] <= COMBO[i*VAL_W +: VAL_W];
    end
    assign gated[i] = pick[i] ? slot_q[i] : '0;
  end

  always_comb begin
    picked = '0;
    for (int k = 0; k < STEPS; k++) picked = picked | gated[k];
  end

  // R2: at most one slot is ever selected
  p_pick_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pick));
endmodule

// File: rtl/lock_cmp.sv
module lock_cmp #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         same
);
  assign same = (a == b);
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import lock_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            defer_verdict,
  input  logic            strobe,
  input  logic            hit,
  output logic [ST_W-1:0] state_q
);
  logic [ST_W-1:0] state_d;
  logic            miss_q, miss_d;

  always_comb begin
    state_d = state_q;
    miss_d  = miss_q;
    unique case (state_q)
      ST_ONE, ST_TWO: begin
        if (strobe) begin
          if (defer_verdict) begin
            state_d = {state_q[ST_W-2:0], 1'b0};
            miss_d  = miss_q | ~hit;
          end else begin
            state_d = hit ? {state_q[ST_W-2:0], 1'b0} : ST_LOCKOUT;
          end
        end
      end
      ST_THREE: begin
        if (strobe) begin
          state_d = (hit && !miss_q) ? ST_OPEN : ST_LOCKOUT;
          miss_d  = 1'b0;
        end
      end
      ST_OPEN:    state_d = ST_OPEN;
      ST_LOCKOUT: state_d = ST_LOCKOUT;
      default:    state_d = ST_LOCKOUT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_ONE;
      miss_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      miss_q  <= miss_d;
    end
  end

  // R1 / R8: reset always lands in step one
  p_reset_step_one_r8: assert property (@(posedge clk)
    rst |=> (state_q == ST_ONE));
  // R4: no strobe, no move
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(state_q));
  // R7: terminal states hold
  p_open_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OPEN) |=> (state_q == ST_OPEN));
  p_lockout_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOCKOUT) |=> (state_q == ST_LOCKOUT));
  // R6: immediate lockout on mismatch in normal mode
  p_mismatch_lockout_r6: assert property (@(posedge clk) disable iff (rst)
    (!defer_verdict && strobe && !hit && (state_q[ST_W-1] == 1'b0) && (state_q != ST_LOCKOUT))
    |=> (state_q == ST_LOCKOUT));
  // R9: deferred mode keeps stepping in step one
  p_defer_advance_r9: assert property (@(posedge clk) disable iff (rst)
    (defer_verdict && strobe && (state_q == ST_ONE)) |=> (state_q == ST_TWO));
  // R5: matching strobe in step three opens in normal mode
  p_match_open_r5: assert property (@(posedge clk) disable iff (rst)
    (!defer_verdict && strobe && hit && (state_q == ST_THREE)) |=> (state_q == ST_OPEN));
endmodule

// File: rtl/seq_lock.sv
module seq_lock
  import lock_pkg::*;
#(
  parameter int VAL_W = 4,
  parameter logic [STEPS*VAL_W-1:0] COMBO = {VAL_W'(2), VAL_W'(4), VAL_W'(3)}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             defer_verdict,
  input  logic             strobe,
  input  logic [VAL_W-1:0] entry,
  output logic             unlocked,
  output logic [STEPS-1:0] sel
);
  logic [ST_W-1:0]  state;
  logic [VAL_W-1:0] stored;
  logic             hit;

  lock_key_store #(.VAL_W(VAL_W), .COMBO(COMBO)) u_store (
    .clk    (clk),
    .rst    (rst),
    .pick   (state[STEPS-1:0]),
    .picked (stored)
  );

  lock_cmp #(.W(VAL_W)) u_cmp (
    .a    (entry),
    .b    (stored),
    .same (hit)
  );

  lock_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .defer_verdict (defer_verdict),
    .strobe        (strobe),
    .hit           (hit),
    .state_q       (state)
  );

  assign sel      = state[STEPS-1:0];
  assign unlocked = state[ST_W-1];

  // R3: unlocked never coexists with an active select
  p_open_no_select_r3: assert property (@(posedge clk) disable iff (rst)
    unlocked |-> (sel == '0));
endmodule

// File: tb/tb_seq_lock.sv
module tb_seq_lock;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       defer_verdict = 1'b0;
  logic       strobe = 1'b0;
  logic [3:0] entry = '0;
  logic       unlocked;
  logic [2:0] sel;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  seq_lock dut (
    .clk(clk), .rst(rst), .defer_verdict(defer_verdict),
    .strobe(strobe), .entry(entry), .unlocked(unlocked), .sel(sel)
  );

  // {rst, defer, strobe, entry[3:0], exp_sel[2:0], exp_open, req[3:0]}
  localparam int NV = 37;
  localparam logic [14:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,4'd0,3'b001,1'b0,4'd1},  // R1 reset
    {1'b0,1'b0,1'b0,4'd3,3'b001,1'b0,4'd4},  // R4 idle
    {1'b0,1'b0,1'b1,4'd3,3'b010,1'b0,4'd5},  // R5 first ok
    {1'b0,1'b0,1'b0,4'd9,3'b010,1'b0,4'd4},  // R4 idle junk
    {1'b0,1'b0,1'b1,4'd4,3'b100,1'b0,4'd5},  // R5 second ok
    {1'b0,1'b0,1'b1,4'd2,3'b000,1'b1,4'd3},  // R3 open
    {1'b0,1'b0,1'b1,4'd5,3'b000,1'b1,4'd7},  // R7 open holds
    {1'b0,1'b0,1'b0,4'd0,3'b000,1'b1,4'd7},  // R7
    {1'b1,1'b0,1'b0,4'd0,3'b001,1'b0,4'd8},  // R8 reset from open
    {1'b0,1'b0,1'b1,4'd7,3'b000,1'b0,4'd6},  // R6 miss step one
    {1'b0,1'b0,1'b1,4'd3,3'b000,1'b0,4'd7},  // R7 lockout holds
    {1'b1,1'b0,1'b0,4'd0,3'b001,1'b0,4'd8},  // R8 reset from lockout
    {1'b0,1'b0,1'b1,4'd3,3'b010,1'b0,4'd5},  // R5
    {1'b0,1'b0,1'b1,4'd3,3'b000,1'b0,4'd6},  // R6 miss step two
    {1'b1,1'b0,1'b0,4'd0,3'b001,1'b0,4'd8},  // R8
    {1'b0,1'b0,1'b1,4'd3,3'b010,1'b0,4'd5},  // R5
    {1'b0,1'b0,1'b1,4'd4,3'b100,1'b0,4'd5},  // R5
    {1'b0,1'b0,1'b1,4'd4,3'b000,1'b0,4'd6},  // R6 miss step three
    {1'b1,1'b1,1'b0,4'd0,3'b001,1'b0,4'd1},  // R1 reset into deferred mode
    {1'b0,1'b1,1'b1,4'd8,3'b010,1'b0,4'd9},  // R9 wrong first, still steps
    {1'b0,1'b1,1'b0,4'd8,3'b010,1'b0,4'd4},  // R4 idle
    {1'b0,1'b1,1'b1,4'd4,3'b100,1'b0,4'd9},  // R9
    {1'b0,1'b1,1'b1,4'd2,3'b000,1'b0,4'd9},  // R9 verdict: lockout
    {1'b0,1'b1,1'b1,4'd3,3'b000,1'b0,4'd7},  // R7
    {1'b1,1'b1,1'b0,4'd0,3'b001,1'b0,4'd8},  // R8
    {1'b0,1'b1,1'b1,4'd3,3'b010,1'b0,4'd9},  // R9
    {1'b0,1'b1,1'b1,4'd1,3'b100,1'b0,4'd9},  // R9 wrong second, still steps
    {1'b0,1'b1,1'b1,4'd2,3'b000,1'b0,4'd9},  // R9 verdict: lockout
    {1'b1,1'b1,1'b0,4'd0,3'b001,1'b0,4'd8},  // R8
    {1'b0,1'b1,1'b1,4'd3,3'b010,1'b0,4'd9},  // R9
    {1'b0,1'b1,1'b1,4'd4,3'b100,1'b0,4'd9},  // R9
    {1'b0,1'b1,1'b1,4'd6,3'b000,1'b0,4'd9},  // R9 wrong third
    {1'b1,1'b1,1'b0,4'd0,3'b001,1'b0,4'd8},  // R8
    {1'b0,1'b1,1'b1,4'd3,3'b010,1'b0,4'd10}, // R10
    {1'b0,1'b1,1'b1,4'd4,3'b100,1'b0,4'd10}, // R10
    {1'b0,1'b1,1'b1,4'd2,3'b000,1'b1,4'd10}, // R10 opens
    {1'b1,1'b0,1'b0,4'd0,3'b001,1'b0,4'd2}   // R2 back to step one
  };

  task automatic apply(input logic r, input logic d, input logic s,
                       input logic [3:0] v, input logic [2:0] es,
                       input logic eo, input int req);
    @(negedge clk);
    rst = r; defer_verdict = d; strobe = s; entry = v;
    @(posedge clk);
    #1;
    n_chk++;
    if (sel !== es || unlocked !== eo) begin
      n_fail++;
      $display("FAIL R%0d: sel=%b unlocked=%b expected sel=%b unlocked=%b",
               req, sel, unlocked, es, eo);
    end
  endtask

  initial begin
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][14], VEC[i][13], VEC[i][12], VEC[i][11:8],
            VEC[i][7:5], VEC[i][4], int'(VEC[i][3:0]));
    end
    // R8: reset beats a matching strobe, from step two
    apply(1'b0, 1'b0, 1'b1, 4'd3, 3'b010, 1'b0, 5);
    apply(1'b1, 1'b0, 1'b1, 4'd4, 3'b001, 1'b0, 8);
    // R5: step one must not accept the value stored for step two
    apply(1'b0, 1'b0, 1'b1, 4'd4, 3'b000, 1'b0, 5);
    apply(1'b1, 1'b0, 1'b0, 4'd0, 3'b001, 1'b0, 8);
    // R5: step two must not accept step three's value
    apply(1'b0, 1'b0, 1'b1, 4'd3, 3'b010, 1'b0, 5);
    apply(1'b0, 1'b0, 1'b1, 4'd2, 3'b000, 1'b0, 5);
    @(negedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule